// File: doc/BRIEF.md
# Serial Wire Debug Line Reset Sequencer

This block brings a debug port into serial wire mode before any register traffic takes place. When a start pulse arrives it takes the clock and data pins. It clocks out a long run of ones on the data line, then the 16-bit mode switch code 0xE79E, then a second long run of ones, and then a short run of low idle bits. The full pattern goes out every time, even if the target already speaks serial wire. The port is only usable after a fresh identification read, so the sequencer always asks for one at the end.

Once the idle bits are done, the sequencer parks the clock high and releases the data driver. It then asks an external transaction engine to perform the identification read, using request byte 0xA5. The engine reports back with an acknowledge pulse and an OK flag. The sequencer records either a connected status or a no-connection status. Any result other than an immediate OK counts as no connection. The bit rate comes from a clock-divider value that is captured when the sequence starts.

Top module: `swd_line_reset`

## Requirements
- R1: After reset, and whenever no sequence is running, `swclk` is 1, `swdio_oe` is 0, `eng_req` is 0 and `busy` is 0. After reset, `connected` and `no_conn` are also 0.
- R2: The first ONES_LEN (64) data bits sampled at rising `swclk` edges are all 1.
- R3: Data bits 64 to 79 carry the switch code 16'hE79E, least significant bit first. Bit 64 is code bit 0.
- R4: Data bits 80 to 143 are all 1.
- R5: The last IDLE_LEN (8) data bits, 144 to 151, are 0. Exactly 152 rising edges are sent while `swdio_oe` is 1.
- R6: `swdio_oe` stays 1 from the start cycle through the high half of the final bit. `swdio_o` changes only in a cycle where `swclk` is 0.
- R7: Each low half and each high half of `swclk` lasts `clk_div`+1 system clock cycles. The divider is captured at start, so changing `clk_div` during a sequence has no effect.
- R8: After the final bit, `swclk` stays 1 and `swdio_oe` drops to 0. In the same cycle `eng_req` rises with `eng_cmd` = 8'hA5. `eng_req` holds until `eng_ack` is seen.
- R9: When `eng_ack` arrives, `eng_ok`=1 sets `connected`, and `eng_ok`=0 sets `no_conn`. Both flags are never high together. The result holds until the next start, which clears both flags.
- R10: A `start` pulse is ignored while `busy` is 1. An `eng_ack` pulse is ignored outside the handoff wait.
- R11: A start that follows a finished connection sends the complete 152-bit pattern again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a connect sequence |
| clk_div | input | DIV_W | Half-period length minus one, in system cycles |
| eng_ack | input | 1 | Transaction engine finished the identification read |
| eng_ok | input | 1 | Engine result was OK; valid with `eng_ack` |
| eng_req | output | 1 | Request to the engine for the identification read |
| eng_cmd | output | 8 | Request byte handed to the engine (0xA5) |
| swclk | output | 1 | Serial wire clock |
| swdio_o | output | 1 | Serial wire data out |
| swdio_oe | output | 1 | Data output enable |
| busy | output | 1 | Sequence or handoff in progress |
| connected | output | 1 | Last identification read succeeded |
| no_conn | output | 1 | Last identification read failed |

## Verification
Two events can land in the same cycle. One is the engine's acknowledge, which ends the handoff. The other is a new start request, which must be refused because the block is still busy in that cycle. The bench drives both in the same cycle. It then checks three things: the result flag follows `eng_ok`, the block returns to idle, and no second pattern begins. A related case is also covered. Here a stray acknowledge and a second start arrive in the middle of the bit pattern. The bench checks that the 152-bit count, the timing and the cleared status are all unaffected.

// File: rtl/swd_line_reset.sv
module swd_line_reset #(
  parameter int          DIV_W       = 8,
  parameter int          ONES_LEN    = 64,
  parameter int          IDLE_LEN    = 8,
  parameter logic [15:0] SWITCH_CODE = 16'hE79E,
  parameter logic [7:0]  ID_REQ      = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             eng_ack,
  input  logic             eng_ok,
  output logic             eng_req,
  output logic [7:0]       eng_cmd,
  output logic             swclk,
  output logic             swdio_o,
  output logic             swdio_oe,
  output logic             busy,
  output logic             connected,
  output logic             no_conn
);
  localparam int MAXLEN = (ONES_LEN > 16) ? ONES_LEN : 16;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  typedef enum logic [2:0] {P_IDLE, P_ONES_A, P_CODE, P_ONES_B, P_LOWS, P_HAND} phase_t;

  phase_t           phase, next_phase;
  logic [CNT_W-1:0] bit_cnt;
  logic [DIV_W-1:0] hc, div_q;
  logic [CNT_W-1:0] phase_last;
  logic             last_bit, half_end;
  logic             clk_q, dout_q, oe_q, conn_q, nc_q;

  function automatic logic bit_of(phase_t ph, logic [CNT_W-1:0] idx);
    case (ph)
      P_ONES_A, P_ONES_B: bit_of = 1'b1;
      P_CODE:             bit_of = SWITCH_CODE[idx[3:0]];
      default:            bit_of = 1'b0;
    endcase
  endfunction

  always_comb begin
    case (phase)
      P_ONES_A, P_ONES_B: phase_last = CNT_W'(ONES_LEN - 1);
      P_CODE:             phase_last = CNT_W'(15);
      P_LOWS:             phase_last = CNT_W'(IDLE_LEN - 1);
      default:            phase_last = '0;
    endcase
    case (phase)
      P_ONES_A: next_phase = P_CODE;
      P_CODE:   next_phase = P_ONES_B;
      P_ONES_B: next_phase = P_LOWS;
      P_LOWS:   next_phase = P_HAND;
      default:  next_phase = P_IDLE;
    endcase
  end

  assign last_bit = (bit_cnt == phase_last);
  assign half_end = (hc == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= P_IDLE;
      bit_cnt <= '0;
      hc      <= '0;
      div_q   <= '0;
      clk_q   <= 1'b1;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
      conn_q  <= 1'b0;
      nc_q    <= 1'b0;
    end else begin
      case (phase)
        P_IDLE: if (start) begin
          phase   <= P_ONES_A;
          bit_cnt <= '0;
          hc      <= '0;
          div_q   <= clk_div;
          clk_q   <= 1'b0;
          dout_q  <= bit_of(P_ONES_A, '0);
          oe_q    <= 1'b1;
          conn_q  <= 1'b0;
          nc_q    <= 1'b0;
        end
        P_HAND: if (eng_ack) begin
          phase  <= P_IDLE;
          conn_q <= eng_ok;
          nc_q   <= !eng_ok;
        end
        default: begin
          if (!half_end) begin
            hc <= hc + 1'b1;
          end else begin
            hc <= '0;
            if (!clk_q) begin
              clk_q <= 1'b1;
            end else if (!last_bit) begin
              bit_cnt <= bit_cnt + 1'b1;
              clk_q   <= 1'b0;
              dout_q  <= bit_of(phase, bit_cnt + 1'b1);
            end else if (next_phase == P_HAND) begin
              phase  <= P_HAND;
              oe_q   <= 1'b0;
              dout_q <= 1'b0;
            end else begin
              phase   <= next_phase;
              bit_cnt <= '0;
              clk_q   <= 1'b0;
              dout_q  <= bit_of(next_phase, '0);
            end
          end
        end
      endcase
    end
  end

  assign swclk     = clk_q;
  assign swdio_o   = dout_q;
  assign swdio_oe  = oe_q;
  assign busy      = (phase != P_IDLE);
  assign eng_req   = (phase == P_HAND);
  assign eng_cmd   = ID_REQ;
  assign connected = conn_q;
  assign no_conn   = nc_q;
endmodule

// File: rtl/swd_line_reset_chk.sv
module swd_line_reset_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic eng_ack,
  input logic eng_req,
  input logic [7:0] eng_cmd,
  input logic swclk,
  input logic swdio_o,
  input logic swdio_oe,
  input logic busy,
  input logic connected,
  input logic no_conn
);
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swclk && !swdio_oe && !eng_req));

  assert_data_moves_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (swdio_oe && $past(swdio_oe) && (swdio_o != $past(swdio_o))) |-> !swclk);

  assert_handoff_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> (swclk && !swdio_oe && eng_cmd == 8'hA5));

  assert_req_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> eng_req);

  assert_status_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(connected && no_conn));

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !connected && !no_conn));

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_req && start) |=> busy);
endmodule

bind swd_line_reset swd_line_reset_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .eng_ack(eng_ack),
  .eng_req(eng_req), .eng_cmd(eng_cmd), .swclk(swclk), .swdio_o(swdio_o),
  .swdio_oe(swdio_oe), .busy(busy), .connected(connected), .no_conn(no_conn)
);

// File: tb/tb_swd_line_reset.sv
`timescale 1ns/1ps
module tb_swd_line_reset;
  localparam logic [15:0] CODE_W = 16'hE79E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] clk_div = 8'd0;
  logic eng_ack = 1'b0;
  logic eng_ok = 1'b0;
  logic eng_req, swclk, swdio_o, swdio_oe, busy, connected, no_conn;
  logic [7:0] eng_cmd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic bitlog [0:255];
  int nbits, run_len, run_min, run_max, badbits;
  logic prev_clk, prev_oe;

  always #2.5 clk = ~clk;

  swd_line_reset dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_div(clk_div),
    .eng_ack(eng_ack), .eng_ok(eng_ok), .eng_req(eng_req), .eng_cmd(eng_cmd),
    .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .busy(busy),
    .connected(connected), .no_conn(no_conn)
  );

  task automatic record_run(int len);
    if (len < run_min) run_min = len;
    if (len > run_max) run_max = len;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (swdio_oe) begin
      if (!prev_oe) run_len = 1;
      else if (swclk == prev_clk) run_len++;
      else begin record_run(run_len); run_len = 1; end
      if (prev_oe && !prev_clk && swclk && nbits < 256) begin
        bitlog[nbits] = swdio_o;
        nbits++;
      end
    end else if (prev_oe) begin
      record_run(run_len);
    end
    prev_clk = swclk;
    prev_oe  = swdio_oe;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 150000) begin
    errors++;
    $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
    finish_run();
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    nbits = 0; run_len = 0; run_min = 1000000; run_max = 0;
  endtask

  function automatic logic exp_bit(int i);
    if (i < 64) return 1'b1;
    if (i < 80) return CODE_W[i-64];
    if (i < 144) return 1'b1;
    return 1'b0;
  endfunction

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_req();
    int n = 0;
    while (!eng_req && n < 40000) begin @(negedge clk); n++; end
  endtask

  task automatic check_pattern(string tag);
    badbits = 0;
    for (int i = 0; i < 152; i++) if (i < nbits && bitlog[i] !== exp_bit(i)) badbits++;
    check({tag, " R5 bit count"}, nbits, 152);
    check({tag, " R2 R3 R4 R5 mismatched bits"}, badbits, 0);
  endtask

  task automatic ack(logic ok);
    eng_ok = ok; eng_ack = 1'b1; @(negedge clk); eng_ack = 1'b0; eng_ok = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 swclk", swclk, 1); check("R1 oe", swdio_oe, 0);
    check("R1 req", eng_req, 0); check("R1 busy", busy, 0);
    check("R1 status", {connected, no_conn}, 0);
  endtask

  task automatic t_connect_ok();
    clear_mon(); clk_div = 8'd0;
    pulse_start();
    check("R6 oe at start", swdio_oe, 1);
    check("R6 swclk low at start", swclk, 0);
    wait_req();
    check_pattern("ok");
    check("R8 swclk parked", swclk, 1);
    check("R8 oe released", swdio_oe, 0);
    check("R8 cmd", eng_cmd, 8'hA5);
    repeat (5) @(negedge clk);
    check("R8 req held", eng_req, 1);
    check("R7 half min div0", run_min, 1);
    check("R7 half max div0", run_max, 1);
    ack(1'b1);
    check("R9 connected", {connected, no_conn}, 2'b10);
    check("R1 idle after", {busy, swclk, swdio_oe}, 3'b010);
  endtask

  task automatic t_fail_div3();
    clear_mon(); clk_div = 8'd3;
    pulse_start();
    check("R9 start clears", {connected, no_conn}, 2'b00);
    check("R11 resend busy", busy, 1);
    repeat (100) @(negedge clk);
    clk_div = 8'd9;
    wait_req();
    check_pattern("R11 div3");
    check("R7 half min div3", run_min, 4);
    check("R7 half max div3", run_max, 4);
    ack(1'b0);
    check("R9 no_conn", {connected, no_conn}, 2'b01);
  endtask

  task automatic t_mid_noise();
    clear_mon(); clk_div = 8'd1;
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    ack(1'b1);
    check("R10 ack ignored busy", busy, 1);
    check("R10 ack ignored status", {connected, no_conn}, 2'b00);
    wait_req();
    check_pattern("R10 mid");
    check("R10 status at handoff", {connected, no_conn}, 2'b00);
    check("R10 half max", run_max, 2);
    start = 1'b1; eng_ok = 1'b1; eng_ack = 1'b1;
    @(negedge clk);
    start = 1'b0; eng_ok = 1'b0; eng_ack = 1'b0;
    check("R10 collide status", {connected, no_conn}, 2'b10);
    check("R10 collide idle", busy, 0);
    repeat (4) @(negedge clk);
    check("R10 no restart", {busy, swdio_oe}, 2'b00);
  endtask

  initial begin
    clear_mon(); prev_clk = 1'b1; prev_oe = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_connect_ok();
    t_fail_div3();
    t_mid_noise();
    finish_run();
  end
endmodule